// File: doc/BRIEF.md
# Burst-Grouping Reorder Streamer

This block sits between a matrix engine and a memory built from 32-bit word ports. A wide read burst of 512 bits is taken from the engine and split into 16 word requests. The word requests go to a downstream arbiter that takes no more than 7 of them per cycle, so one burst goes out over three cycles. Each word request carries a tag that names its reorder slot and its lane. The memory may answer the word requests in any order, on several reply ports at once.

The replies are written into a 16-slot reorder store. The oldest slot is handed back to the engine as one full 512-bit burst as soon as all 16 of its words have arrived. Bursts therefore reach the engine in the order it asked for them. A new read burst is taken only while a slot is free.

A separate 32-entry queue holds the engine's result bursts on their way to memory. It pushes back on the engine when it is full, and it passes the bursts on in the order they were written.

Top module: `burst_reorder_streamer`

## Requirements
- R1: `rd_req_ready_o` is low whenever 16 bursts have been accepted and not yet handed back, so a 17th burst is not taken.
- R2: Burst `k` after reset uses reorder slot `k mod 16`. Its lane `l` word request has address base + 4*l and an 8-bit tag, with the slot in bits [7:4] and the lane in bits [3:0].
- R3: A burst's word requests go out in ascending lane order, at most 7 per cycle, all from the same slot within a cycle. A burst accepted at clock edge E with nothing ahead of it issues lanes 0-6 in the cycle after E, then lanes 7-13, then lanes 14-15. In the port vectors the slot for lane offset j is index j.
- R4: Word replies are accepted on any of 4 reply ports, in any order and any mix per cycle. Every requested word is consumed exactly once.
- R5: Wide bursts are returned in acceptance order. Lane `l` of a burst sits in bits [32l+31:32l] of `rd_rsp_data_o`.
- R6: The oldest burst is offered only once all 16 of its words are present. `rd_rsp_valid_o` rises in the cycle after the clock edge that stores the last word.
- R7: While `rd_rsp_valid_o` is high and `rd_rsp_ready_i` is low, the valid and the data stay unchanged.
- R8: The result queue holds 32 bursts and returns them in write order. `wr_ready_o` is low exactly when it holds 32, and `zq_valid_o` is high exactly when it holds at least one.
- R9: After reset, `rd_req_ready_o` and `wr_ready_o` are high, and `rd_rsp_valid_o`, `zq_valid_o` and all `nreq_valid_o` bits are low.
- R10: When a burst is handed back while 16 were outstanding, `rd_req_ready_o` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_valid_i | input | 1 | Engine read burst request valid |
| rd_req_ready_o | output | 1 | A reorder slot is free |
| rd_req_addr_i | input | 32 | Byte base address of the burst |
| nreq_valid_o | output | 7 | Word request valid per issue slot |
| nreq_addr_o | output | 224 | Word addresses, 32 bits per issue slot |
| nreq_tag_o | output | 56 | Word tags, 8 bits per issue slot |
| nrsp_valid_i | input | 4 | Word reply valid per reply port |
| nrsp_tag_i | input | 32 | Tag echoed with each reply, 8 bits per port |
| nrsp_data_i | input | 128 | Reply word, 32 bits per port |
| rd_rsp_valid_o | output | 1 | Rebuilt burst valid |
| rd_rsp_ready_i | input | 1 | Engine takes the rebuilt burst |
| rd_rsp_data_o | output | 512 | Rebuilt burst |
| wr_valid_i | input | 1 | Engine result burst valid |
| wr_ready_o | output | 1 | Result queue has room |
| wr_data_i | input | 512 | Result burst from engine |
| zq_valid_o | output | 1 | Result burst available to memory |
| zq_ready_i | input | 1 | Memory side takes the result burst |
| zq_data_o | output | 512 | Result burst to memory |

## Verification
Three things can land on one clock edge: the oldest slot is handed back, a new burst claims a slot, and word replies are written into younger slots. The random phase provokes this by keeping requests, several reply ports and the engine's ready active together, with replies chosen in random order. Each returned burst is compared with a model built from the request order and an address-derived data function. The checker tracks outstanding counts, so a slot lost or reused early shows up as a data mismatch or a count violation.

// File: rtl/brs_pkg.sv
package brs_pkg;
  localparam int unsigned BRS_BURST_W   = 512;
  localparam int unsigned BRS_WORD_W    = 32;
  localparam int unsigned BRS_ROB_DEPTH = 16;
  localparam int unsigned BRS_ISSUE_CAP = 7;
  localparam int unsigned BRS_RSP_PORTS = 4;
  localparam int unsigned BRS_ZQ_DEPTH  = 32;
  localparam int unsigned BRS_ADDR_W    = 32;
endpackage

// File: rtl/brs_issue.sv
module brs_issue #(
  parameter int unsigned LANES      = 16,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned ROB_DEPTH  = 16,
  parameter int unsigned ISSUE_CAP  = 7,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned LANE_W     = 4,
  localparam int unsigned TAG_W     = IDX_W + LANE_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          alloc_i,
  input  logic [IDX_W-1:0]              alloc_idx_i,
  input  logic [ADDR_W-1:0]             alloc_addr_i,
  output logic [ISSUE_CAP-1:0]          nreq_valid_o,
  output logic [ISSUE_CAP*ADDR_W-1:0]   nreq_addr_o,
  output logic [ISSUE_CAP*TAG_W-1:0]    nreq_tag_o
);
  localparam int unsigned CNT_W = $clog2(ROB_DEPTH + 1);

  logic [ADDR_W-1:0] base_q [ROB_DEPTH];
  logic [CNT_W-1:0]  pend_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LANE_W-1:0] lane_q;
  logic              pend;
  logic              last;

  assign pend = (pend_q != '0);
  // final group of the current burst goes out this cycle
  assign last = pend && ((32'(lane_q) + ISSUE_CAP) >= LANES);

  always_comb begin
    for (int k = 0; k < ISSUE_CAP; k++) begin
      int unsigned ln;
      ln = 32'(lane_q) + 32'(k);
      nreq_valid_o[k]                   = pend && (ln < LANES);
      nreq_addr_o[k*ADDR_W +: ADDR_W]   = base_q[idx_q] + ADDR_W'(ln * WORD_BYTES);
      nreq_tag_o[k*TAG_W +: TAG_W]      = {idx_q, LANE_W'(ln)};
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_i) base_q[alloc_idx_i] <= alloc_addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      idx_q  <= '0;
      lane_q <= '0;
    end else begin
      pend_q <= pend_q + CNT_W'(alloc_i) - CNT_W'(last);
      if (last) begin
        lane_q <= '0;
        idx_q  <= idx_q + 1'b1;
      end else if (pend) begin
        lane_q <= lane_q + LANE_W'(ISSUE_CAP);
      end
    end
  end
endmodule

// File: rtl/brs_rob.sv
module brs_rob #(
  parameter int unsigned LANES     = 16,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned ROB_DEPTH = 16,
  parameter int unsigned RSP_PORTS = 4,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned LANE_W    = 4,
  localparam int unsigned TAG_W    = IDX_W + LANE_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         alloc_i,
  output logic                         free_o,
  output logic [IDX_W-1:0]             alloc_idx_o,
  input  logic [RSP_PORTS-1:0]         rsp_valid_i,
  input  logic [RSP_PORTS*TAG_W-1:0]   rsp_tag_i,
  input  logic [RSP_PORTS*WORD_W-1:0]  rsp_data_i,
  output logic                         out_valid_o,
  input  logic                         out_ready_i,
  output logic [LANES*WORD_W-1:0]      out_data_o
);
  logic [IDX_W:0]      alloc_q, head_q, occ;
  logic [IDX_W-1:0]    head_idx;
  logic [LANES-1:0]    have_q [ROB_DEPTH];
  logic [WORD_W-1:0]   word_q [ROB_DEPTH][LANES];
  logic                release_w;

  assign occ         = alloc_q - head_q;
  assign head_idx    = head_q[IDX_W-1:0];
  assign alloc_idx_o = alloc_q[IDX_W-1:0];
  assign free_o      = (occ != (IDX_W+1)'(ROB_DEPTH));
  assign out_valid_o = (occ != '0) && (&have_q[head_idx]);
  assign release_w   = out_valid_o && out_ready_i;

  always_comb begin
    for (int l = 0; l < LANES; l++) out_data_o[l*WORD_W +: WORD_W] = word_q[head_idx][l];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alloc_q <= '0;
      head_q  <= '0;
      for (int e = 0; e < ROB_DEPTH; e++) have_q[e] <= '0;
    end else begin
      if (alloc_i) begin
        alloc_q               <= alloc_q + 1'b1;
        have_q[alloc_idx_o]   <= '0;
      end
      for (int p = 0; p < RSP_PORTS; p++) begin
        if (rsp_valid_i[p])
          have_q[rsp_tag_i[p*TAG_W+LANE_W +: IDX_W]][rsp_tag_i[p*TAG_W +: LANE_W]] <= 1'b1;
      end
      if (release_w) head_q <= head_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    for (int p = 0; p < RSP_PORTS; p++) begin
      if (rsp_valid_i[p])
        word_q[rsp_tag_i[p*TAG_W+LANE_W +: IDX_W]][rsp_tag_i[p*TAG_W +: LANE_W]]
          <= rsp_data_i[p*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/brs_fifo.sv
module brs_fifo #(
  parameter int unsigned WIDTH = 512,
  parameter int unsigned DEPTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [WIDTH-1:0] in_data_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [WIDTH-1:0] out_data_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W:0]   wp_q, rp_q;
  logic             push, pop;

  assign in_ready_o  = ((wp_q ^ rp_q) != {1'b1, {PTR_W{1'b0}}});
  assign out_valid_o = (wp_q != rp_q);
  assign out_data_o  = mem_q[rp_q[PTR_W-1:0]];
  assign push        = in_valid_i && in_ready_o;
  assign pop         = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wp_q[PTR_W-1:0]] <= in_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push) wp_q <= wp_q + 1'b1;
      if (pop)  rp_q <= rp_q + 1'b1;
    end
  end
endmodule

// File: rtl/burst_reorder_streamer.sv
module burst_reorder_streamer
  import brs_pkg::*;
#(
  parameter int unsigned BURST_W   = BRS_BURST_W,
  parameter int unsigned WORD_W    = BRS_WORD_W,
  parameter int unsigned ROB_DEPTH = BRS_ROB_DEPTH,
  parameter int unsigned ISSUE_CAP = BRS_ISSUE_CAP,
  parameter int unsigned RSP_PORTS = BRS_RSP_PORTS,
  parameter int unsigned ZQ_DEPTH  = BRS_ZQ_DEPTH,
  parameter int unsigned ADDR_W    = BRS_ADDR_W,
  localparam int unsigned LANES      = BURST_W / WORD_W,
  localparam int unsigned WORD_BYTES = WORD_W / 8,
  localparam int unsigned IDX_W      = $clog2(ROB_DEPTH),
  localparam int unsigned LANE_W     = $clog2(LANES),
  localparam int unsigned TAG_W      = IDX_W + LANE_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         rd_req_valid_i,
  output logic                         rd_req_ready_o,
  input  logic [ADDR_W-1:0]            rd_req_addr_i,
  output logic [ISSUE_CAP-1:0]         nreq_valid_o,
  output logic [ISSUE_CAP*ADDR_W-1:0]  nreq_addr_o,
  output logic [ISSUE_CAP*TAG_W-1:0]   nreq_tag_o,
  input  logic [RSP_PORTS-1:0]         nrsp_valid_i,
  input  logic [RSP_PORTS*TAG_W-1:0]   nrsp_tag_i,
  input  logic [RSP_PORTS*WORD_W-1:0]  nrsp_data_i,
  output logic                         rd_rsp_valid_o,
  input  logic                         rd_rsp_ready_i,
  output logic [BURST_W-1:0]           rd_rsp_data_o,
  input  logic                         wr_valid_i,
  output logic                         wr_ready_o,
  input  logic [BURST_W-1:0]           wr_data_i,
  output logic                         zq_valid_o,
  input  logic                         zq_ready_i,
  output logic [BURST_W-1:0]           zq_data_o
);
  logic             alloc;
  logic             rob_free;
  logic [IDX_W-1:0] alloc_idx;

  assign rd_req_ready_o = rob_free;
  assign alloc          = rd_req_valid_i && rob_free;

  brs_rob #(
    .LANES(LANES), .WORD_W(WORD_W), .ROB_DEPTH(ROB_DEPTH),
    .RSP_PORTS(RSP_PORTS), .IDX_W(IDX_W), .LANE_W(LANE_W)
  ) u_rob (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_i     (alloc),
    .free_o      (rob_free),
    .alloc_idx_o (alloc_idx),
    .rsp_valid_i (nrsp_valid_i),
    .rsp_tag_i   (nrsp_tag_i),
    .rsp_data_i  (nrsp_data_i),
    .out_valid_o (rd_rsp_valid_o),
    .out_ready_i (rd_rsp_ready_i),
    .out_data_o  (rd_rsp_data_o)
  );

  brs_issue #(
    .LANES(LANES), .WORD_BYTES(WORD_BYTES), .ROB_DEPTH(ROB_DEPTH),
    .ISSUE_CAP(ISSUE_CAP), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LANE_W(LANE_W)
  ) u_issue (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_i      (alloc),
    .alloc_idx_i  (alloc_idx),
    .alloc_addr_i (rd_req_addr_i),
    .nreq_valid_o (nreq_valid_o),
    .nreq_addr_o  (nreq_addr_o),
    .nreq_tag_o   (nreq_tag_o)
  );

  brs_fifo #(.WIDTH(BURST_W), .DEPTH(ZQ_DEPTH)) u_zq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (wr_valid_i),
    .in_ready_o  (wr_ready_o),
    .in_data_i   (wr_data_i),
    .out_valid_o (zq_valid_o),
    .out_ready_i (zq_ready_i),
    .out_data_o  (zq_data_o)
  );
endmodule

// File: rtl/brs_chk.sv
module brs_chk #(
  parameter int unsigned BURST_W   = 512,
  parameter int unsigned ROB_DEPTH = 16,
  parameter int unsigned ISSUE_CAP = 7,
  parameter int unsigned ZQ_DEPTH  = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 rd_req_valid_i,
  input logic                 rd_req_ready_o,
  input logic [ISSUE_CAP-1:0] nreq_valid_o,
  input logic                 rd_rsp_valid_o,
  input logic                 rd_rsp_ready_i,
  input logic [BURST_W-1:0]   rd_rsp_data_o,
  input logic                 wr_valid_i,
  input logic                 wr_ready_o,
  input logic                 zq_valid_o,
  input logic                 zq_ready_i
);
  int unsigned out_cnt;
  int unsigned z_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_cnt <= 0;
      z_cnt   <= 0;
    end else begin
      out_cnt <= out_cnt + 32'(rd_req_valid_i && rd_req_ready_o) - 32'(rd_rsp_valid_o && rd_rsp_ready_i);
      z_cnt   <= z_cnt + 32'(wr_valid_i && wr_ready_o) - 32'(zq_valid_o && zq_ready_i);
    end
  end

  // R1
  rob_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_cnt == ROB_DEPTH) |-> !rd_req_ready_o);
  // R10
  rob_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_cnt < ROB_DEPTH) |-> rd_req_ready_o);
  // R6
  rsp_need_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rsp_valid_o |-> (out_cnt != 0));
  // R7
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rsp_valid_o && !rd_rsp_ready_i) |=> (rd_rsp_valid_o && $stable(rd_rsp_data_o)));
  // R3
  issue_need_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|nreq_valid_o) |-> (out_cnt != 0));
  // R8
  zq_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (z_cnt == ZQ_DEPTH) |-> !wr_ready_o);
  // R8
  zq_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (z_cnt < ZQ_DEPTH) |-> wr_ready_o);
  // R8
  zq_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zq_valid_o == (z_cnt != 0));
endmodule

bind burst_reorder_streamer brs_chk #(
  .BURST_W(BURST_W), .ROB_DEPTH(ROB_DEPTH), .ISSUE_CAP(ISSUE_CAP), .ZQ_DEPTH(ZQ_DEPTH)
) u_chk (.*);

// File: tb/sim_burst_reorder_streamer.sv
module sim_burst_reorder_streamer;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 512;
  localparam int AW = 32;
  localparam int CAP = 7;
  localparam int RP = 4;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rd_req_valid_i = 1'b0;
  logic rd_req_ready_o;
  logic [AW-1:0] rd_req_addr_i = '0;
  logic [CAP-1:0] nreq_valid_o;
  logic [CAP*AW-1:0] nreq_addr_o;
  logic [CAP*TW-1:0] nreq_tag_o;
  logic [RP-1:0] nrsp_valid_i = '0;
  logic [RP*TW-1:0] nrsp_tag_i = '0;
  logic [RP*32-1:0] nrsp_data_i = '0;
  logic rd_rsp_valid_o;
  logic rd_rsp_ready_i = 1'b0;
  logic [BW-1:0] rd_rsp_data_o;
  logic wr_valid_i = 1'b0;
  logic wr_ready_o;
  logic [BW-1:0] wr_data_i = '0;
  logic zq_valid_o;
  logic zq_ready_i = 1'b0;
  logic [BW-1:0] zq_data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_reorder_streamer u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .rd_req_valid_i(rd_req_valid_i), .rd_req_ready_o(rd_req_ready_o), .rd_req_addr_i(rd_req_addr_i),
    .nreq_valid_o(nreq_valid_o), .nreq_addr_o(nreq_addr_o), .nreq_tag_o(nreq_tag_o),
    .nrsp_valid_i(nrsp_valid_i), .nrsp_tag_i(nrsp_tag_i), .nrsp_data_i(nrsp_data_i),
    .rd_rsp_valid_o(rd_rsp_valid_o), .rd_rsp_ready_i(rd_rsp_ready_i), .rd_rsp_data_o(rd_rsp_data_o),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .wr_data_i(wr_data_i),
    .zq_valid_o(zq_valid_o), .zq_ready_i(zq_ready_i), .zq_data_o(zq_data_o)
  );

  int n_tests = 0;
  int n_fail = 0;
  logic [7:0]  pool_tag [1024];
  logic [31:0] pool_addr [1024];
  int pool_n = 0;
  bit hold_en = 1'b0;
  logic [7:0] hold_tag = '0;
  logic [31:0] exp_q [$];
  logic [BW-1:0] z_q [$];

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A1234;
  endfunction

  function automatic logic [BW-1:0] exp_burst(input logic [31:0] base);
    logic [BW-1:0] r;
    for (int l = 0; l < 16; l++) r[l*32 +: 32] = mem_word(base + 32'(l*4));
    return r;
  endfunction

  function automatic logic [BW-1:0] rand_burst();
    logic [BW-1:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom();
    return r;
  endfunction

  function automatic logic [31:0] rand_addr();
    logic [31:0] t;
    t = $urandom();
    return {t[31:6], 6'd0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle(input bit req_en, input logic [31:0] req_addr, input int rsp_max,
                       input bit out_rdy, input bit zw_en, input bit zr_rdy);
    @(negedge clk);
    rd_req_valid_i = req_en;
    rd_req_addr_i  = req_addr;
    nrsp_valid_i   = '0;
    for (int p = 0; p < RP; p++) begin
      if (p < rsp_max && pool_n > 0) begin
        int j;
        j = int'($urandom() % 32'(pool_n));
        if (!(hold_en && pool_tag[j] == hold_tag)) begin
          nrsp_valid_i[p]        = 1'b1;
          nrsp_tag_i[p*TW +: TW] = pool_tag[j];
          nrsp_data_i[p*32 +: 32] = mem_word(pool_addr[j]);
          pool_n--;
          pool_tag[j]  = pool_tag[pool_n];
          pool_addr[j] = pool_addr[pool_n];
        end
      end
    end
    rd_rsp_ready_i = out_rdy;
    wr_valid_i     = zw_en;
    wr_data_i      = rand_burst();
    zq_ready_i     = zr_rdy;
    #1;
    if (rd_req_valid_i && rd_req_ready_o) exp_q.push_back(rd_req_addr_i);
    if (rd_rsp_valid_o && rd_rsp_ready_i) begin
      if (exp_q.size() == 0) chk(1'b0, "R5", rd_rsp_data_o, '0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(rd_rsp_data_o == exp_burst(e), "R5", rd_rsp_data_o, exp_burst(e));
      end
    end
    if (|nreq_valid_o) begin
      bit same;
      same = 1'b1;
      for (int k = 0; k < CAP; k++) begin
        if (nreq_valid_o[k]) begin
          if (nreq_tag_o[k*TW+4 +: 4] != nreq_tag_o[7:4]) same = 1'b0;
          pool_tag[pool_n]  = nreq_tag_o[k*TW +: TW];
          pool_addr[pool_n] = nreq_addr_o[k*AW +: AW];
          pool_n++;
        end
      end
      chk(same, "R3", BW'(nreq_tag_o), BW'(nreq_tag_o[7:4]));
    end
    if (wr_valid_i && wr_ready_o) z_q.push_back(wr_data_i);
    if (zq_valid_o && zq_ready_i) begin
      if (z_q.size() == 0) chk(1'b0, "R8", zq_data_o, '0);
      else begin
        logic [BW-1:0] z;
        z = z_q.pop_front();
        chk(zq_data_o == z, "R8", zq_data_o, z);
      end
    end
  endtask

  task automatic chk_group(input logic [CAP-1:0] mask, input int first_lane, input logic [31:0] base);
    bit ok;
    chk(nreq_valid_o == mask, "R3", BW'(nreq_valid_o), BW'(mask));
    ok = 1'b1;
    for (int k = 0; k < CAP; k++) begin
      if (mask[k]) begin
        if (nreq_tag_o[k*TW +: TW] != {4'h0, 4'(first_lane + k)}) ok = 1'b0;
        if (nreq_addr_o[k*AW +: AW] != base + 32'((first_lane + k) * 4)) ok = 1'b0;
      end
    end
    chk(ok, "R2", BW'(nreq_addr_o), BW'(base));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R9 reset state
    chk(rd_req_ready_o && wr_ready_o, "R9", BW'({rd_req_ready_o, wr_ready_o}), BW'(2'b11));
    chk(!rd_rsp_valid_o && !zq_valid_o && nreq_valid_o == '0, "R9",
        BW'({rd_rsp_valid_o, zq_valid_o, nreq_valid_o}), '0);

    // R3 / R2: lone burst split into 7,7,2
    cycle(1'b1, 32'h0000_1000, 0, 1'b0, 1'b0, 1'b0);
    cycle(1'b0, 32'h0, 0, 1'b0, 1'b0, 1'b0);
    chk_group(7'h7f, 0, 32'h0000_1000);
    cycle(1'b0, 32'h0, 0, 1'b0, 1'b0, 1'b0);
    chk_group(7'h7f, 7, 32'h0000_1000);
    cycle(1'b0, 32'h0, 0, 1'b0, 1'b0, 1'b0);
    chk_group(7'h03, 14, 32'h0000_1000);
    cycle(1'b0, 32'h0, 0, 1'b0, 1'b0, 1'b0);
    chk(nreq_valid_o == '0, "R3", BW'(nreq_valid_o), '0);

    // R6: 15 of 16 words present -> nothing offered
    hold_en = 1'b1;
    hold_tag = 8'h0F;
    repeat (16) cycle(1'b0, 32'h0, 4, 1'b1, 1'b0, 1'b0);
    chk(!rd_rsp_valid_o, "R6", BW'(rd_rsp_valid_o), '0);
    hold_en = 1'b0;
    cycle(1'b0, 32'h0, 4, 1'b0, 1'b0, 1'b0);
    cycle(1'b0, 32'h0, 0, 1'b0, 1'b0, 1'b0);
    chk(rd_rsp_valid_o, "R6", BW'(rd_rsp_valid_o), BW'(1));
    chk(rd_rsp_data_o == exp_burst(32'h0000_1000), "R5", rd_rsp_data_o, exp_burst(32'h0000_1000));
    cycle(1'b0, 32'h0, 0, 1'b0, 1'b0, 1'b0);
    // R7 held while stalled
    chk(rd_rsp_valid_o && rd_rsp_data_o == exp_burst(32'h0000_1000), "R7",
        rd_rsp_data_o, exp_burst(32'h0000_1000));
    cycle(1'b0, 32'h0, 0, 1'b1, 1'b0, 1'b0);
    cycle(1'b0, 32'h0, 0, 1'b0, 1'b0, 1'b0);
    chk(!rd_rsp_valid_o && exp_q.size() == 0, "R5", BW'(exp_q.size()), '0);

    // R1 / R10: fill all 16 slots
    for (int i = 0; i < 16; i++) begin
      cycle(1'b1, rand_addr(), 0, 1'b0, 1'b0, 1'b0);
      chk(exp_q.size() == i + 1, "R1", BW'(exp_q.size()), BW'(i + 1));
    end
    cycle(1'b1, rand_addr(), 0, 1'b0, 1'b0, 1'b0);
    chk(!rd_req_ready_o && exp_q.size() == 16, "R1", BW'(exp_q.size()), BW'(16));
    repeat (120) cycle(1'b0, 32'h0, 4, 1'b0, 1'b0, 1'b0);
    chk(!rd_req_ready_o && rd_rsp_valid_o, "R1", BW'({rd_req_ready_o, rd_rsp_valid_o}), BW'(2'b01));
    cycle(1'b0, 32'h0, 0, 1'b1, 1'b0, 1'b0);
    cycle(1'b0, 32'h0, 0, 1'b0, 1'b0, 1'b0);
    chk(rd_req_ready_o, "R10", BW'(rd_req_ready_o), BW'(1));
    repeat (40) cycle(1'b0, 32'h0, 4, 1'b1, 1'b0, 1'b0);

    // R8: result queue fill, backpressure, drain in order
    repeat (32) cycle(1'b0, 32'h0, 0, 1'b0, 1'b1, 1'b0);
    cycle(1'b0, 32'h0, 0, 1'b0, 1'b1, 1'b0);
    chk(!wr_ready_o && z_q.size() == 32, "R8", BW'(z_q.size()), BW'(32));
    repeat (40) cycle(1'b0, 32'h0, 0, 1'b0, 1'b0, 1'b1);
    chk(z_q.size() == 0 && !zq_valid_o, "R8", BW'(z_q.size()), '0);

    // random mix: release, allocation and reply writes overlap
    for (int i = 0; i < 3000; i++) begin
      cycle(($urandom() % 4) != 0, rand_addr(), int'($urandom() % 5),
            ($urandom() % 3) != 0, ($urandom() % 2) != 0, ($urandom() % 3) != 0);
    end
    repeat (400) cycle(1'b0, 32'h0, 4, 1'b1, 1'b0, 1'b1);
    // R4 every word consumed, every burst returned
    chk(exp_q.size() == 0 && pool_n == 0, "R4", BW'(exp_q.size() + pool_n), '0);
    chk(z_q.size() == 0, "R8", BW'(z_q.size()), '0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule